// File: doc/BRIEF.md
# Serial EEPROM Bus Slave Controller

This block is the two-wire bus front end of a 1024 x 8 serial memory. It oversamples the bus clock and data lines with the system clock and finds start and stop conditions on the synchronized copies. It shifts in the select byte, the memory address byte and the write data, and it answers each byte on the ninth bus clock. The only drive onto the data line is an enable that pulls it low, used both for acknowledge and for read data.

The controller decodes the select byte and keeps the current address counter. It serves byte writes, page-style bursts that wrap inside a 16-byte page, random reads through a dummy write, current address reads and sequential reads. The storage array sits behind a plain read port and a one-cycle write strobe. A busy flag from the program sequencer makes the block refuse write selects while a program cycle is running.

Top module: `serial_mem_slave`

## Requirements
- R1: A select byte whose bits 7:4 equal 1010 and whose bit 3 equals `sel_pin` is acknowledged: `sda_pull` is high during the ninth bus clock. Bit 0 chooses the transfer: 1 is a read and 0 is a write.
- R2: A select byte that fails R1 gets no acknowledge. Every later byte up to the next start condition is also left unanswered.
- R3: A fall of SDA while SCL is high is a start condition. A rise of SDA while SCL is high is a stop condition. `sda_pull` changes only while the synchronized SCL is low.
- R4: Incoming bits are taken on the SCL rise, MSB first. Read data bits are driven after the SCL fall, MSB first. The ninth clock carries the acknowledge, and low means acknowledge.
- R5: In a write, bits 2:1 of the select byte become address bits 9:8 and the next byte gives bits 7:0. Both bytes are acknowledged. Each data byte is acknowledged and written to the current address with a one-cycle `mem_wr_en`.
- R6: Each written byte advances the address only in its low 4 bits, so a burst wraps inside its 16-byte page and overwrites earlier bytes of that page.
- R7: While `wr_protect` is high, the select byte and the address byte are still acknowledged. Every data byte gets no acknowledge and no write is issued.
- R8: In a read, the byte at the current address follows the select acknowledge. Each master acknowledge of 0 advances the address by one, wrapping from 1023 to 0, and sends the next byte.
- R9: After a master no-acknowledge the block keeps SDA released and sends nothing until a stop or a start.
- R10: The current address is the last accessed address plus one. A random read is a write select plus an address byte, then a repeated start and a read select. Select bits 2:1 are ignored in a read select.
- R11: A repeated start in the middle of any byte restarts the select phase and leaves the current address unchanged.
- R12: While `prog_busy` is high, a write select gets no acknowledge and a read select is served. Once `prog_busy` is low, a write select is acknowledged again.
- R13: After reset the current address is 0 and `sda_pull` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | High pulls the data line low |
| sel_pin | input | 1 | Hard-wired select bit compared with select bit 3 |
| wr_protect | input | 1 | High blocks all data writes |
| prog_busy | input | 1 | Program cycle in progress |
| mem_rd_addr | output | 10 | Current address, read port of the array |
| mem_rd_data | input | 8 | Array data at `mem_rd_addr` |
| mem_wr_en | output | 1 | One-cycle write strobe |
| mem_wr_addr | output | 10 | Write address |
| mem_wr_data | output | 8 | Write data |

## Verification
The assertions assume that SDA moves only while SCL is low, except for start and stop, and that each SCL level lasts several system clocks, so that the synchronizers keep the two lines in order. They also assume that `wr_protect` does not change during the clock that ends a data byte. The bench drives each bus level for eight clocks and changes SDA in the middle of the low phase. It changes `wr_protect` and `prog_busy` only between transactions. The bench models the open-drain line as the AND of the master's level and the inverse of `sda_pull`.

// File: rtl/eeb_pkg.sv
package eeb_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SEL,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_RWAIT
  } phase_t;

  // select byte: fixed code in [7:4], pin-compared bit in [3]
  function automatic logic sel_match(input logic [7:0] b, input logic [3:0] code,
                                     input logic pin);
    return (b[7:4] == code) && (b[3] == pin);
  endfunction

endpackage

// File: rtl/eeb_line_sync.sv
module eeb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw_v;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev;

  assign raw_v = {sda_raw, scl_raw};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw_v[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= synced;
  end

  assign scl_s    = synced[0];
  assign sda_s    = synced[1];
  assign scl_rise = synced[0] & ~prev[0];
  assign scl_fall = ~synced[0] & prev[0];
  assign start_ev = synced[0] & prev[0] & prev[1] & ~synced[1];
  assign stop_ev  = synced[0] & prev[0] & ~prev[1] & synced[1];

endmodule

// File: rtl/eeb_addr_ctr.sv
module eeb_addr_ctr #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              step_seq,
  input  logic              step_page,
  output logic [ADDR_W-1:0] cur
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

  function automatic logic [ADDR_W-1:0] seq_next(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
    logic [PAGE_W-1:0] low;
    low = a[PAGE_W-1:0] + PAGE_W'(1);
    return {a[ADDR_W-1:PAGE_W], low};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cur <= '0;
    else if (ld)        cur <= ld_val;
    else if (step_seq)  cur <= seq_next(cur);
    else if (step_page) cur <= page_next(cur);
  end

  assert_seq_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_seq && !ld && cur == TOP_ADDR) |=> (cur == '0));

  assert_page_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_page && !ld && !step_seq) |=> (cur[ADDR_W-1:PAGE_W] == $past(cur[ADDR_W-1:PAGE_W])));

endmodule

// File: rtl/eeb_protocol.sv
module eeb_protocol
  import eeb_pkg::*;
#(
  parameter int          ADDR_W   = 10,
  parameter logic [3:0]  DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sel_pin,
  input  logic              wr_protect,
  input  logic              prog_busy,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [7:0]        rd_data,
  output logic              sda_pull,
  output logic              ld,
  output logic [ADDR_W-1:0] ld_val,
  output logic              step_seq,
  output logic              step_page,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam int         HI_W     = ADDR_W - 8;
  localparam logic [3:0] DATA_END = 4'd8;
  localparam logic [3:0] ACK_END  = 4'd9;

  phase_t            phase, nxt;
  logic [3:0]        cnt;
  logic [7:0]        shreg, tx;
  logic [HI_W-1:0]   hi;
  logic              tx_go, pull, wr_en_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [7:0]        wr_data_q;

  // named events
  logic active, fall_ack, fall_end, sel_ok, sel_rd, sel_refused;
  logic tx_load, wr_fire, ld_addr, tx_shift;

  assign active      = (phase != PH_IDLE) && (phase != PH_RWAIT);
  assign fall_ack    = active && scl_fall && (cnt == DATA_END);
  assign fall_end    = active && scl_fall && (cnt == ACK_END);
  assign sel_ok      = sel_match(shreg, DEV_CODE, sel_pin);
  assign sel_rd      = shreg[0];
  assign sel_refused = !sel_ok || (!sel_rd && prog_busy);
  assign ld_addr     = fall_ack && (phase == PH_ADDR);
  assign wr_fire     = fall_ack && (phase == PH_WDATA) && !wr_protect;
  assign tx_load     = fall_end && (nxt == PH_RDATA) && tx_go;
  assign tx_shift    = active && scl_fall && (phase == PH_RDATA) &&
                       (cnt != 4'd0) && (cnt < DATA_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      nxt       <= PH_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      tx        <= '0;
      hi        <= '0;
      tx_go     <= 1'b0;
      pull      <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= wr_fire;
      if (wr_fire) begin
        wr_addr_q <= cur_addr;
        wr_data_q <= shreg;
      end
      if (start_ev) begin
        phase <= PH_SEL;
        cnt   <= '0;
        pull  <= 1'b0;
        tx_go <= 1'b0;
      end else if (stop_ev) begin
        phase <= PH_IDLE;
        pull  <= 1'b0;
      end else if (active) begin
        if (scl_rise) begin
          if (cnt < DATA_END) shreg <= {shreg[6:0], sda_s};
          else if (cnt == DATA_END && phase == PH_RDATA) tx_go <= ~sda_s;
          if (cnt != ACK_END) cnt <= cnt + 4'd1;
        end else if (fall_ack) begin
          unique case (phase)
            PH_SEL: begin
              if (sel_refused) begin
                phase <= PH_IDLE;
                pull  <= 1'b0;
              end else begin
                pull  <= 1'b1;
                tx_go <= sel_rd;
                nxt   <= sel_rd ? PH_RDATA : PH_ADDR;
                if (!sel_rd) hi <= shreg[HI_W:1];
              end
            end
            PH_ADDR: begin
              pull <= 1'b1;
              nxt  <= PH_WDATA;
            end
            PH_WDATA: begin
              pull <= !wr_protect;
              nxt  <= PH_WDATA;
            end
            default: begin
              pull <= 1'b0;
              nxt  <= PH_RDATA;
            end
          endcase
        end else if (fall_end) begin
          cnt <= '0;
          if (tx_load) begin
            tx    <= rd_data;
            pull  <= ~rd_data[7];
            phase <= PH_RDATA;
          end else begin
            pull  <= 1'b0;
            phase <= (nxt == PH_RDATA) ? PH_RWAIT : nxt;
          end
        end else if (tx_shift) begin
          tx   <= {tx[6:0], 1'b0};
          pull <= ~tx[6];
        end
      end
    end
  end

  assign sda_pull  = pull;
  assign ld        = ld_addr;
  assign ld_val    = {hi, shreg};
  assign step_seq  = tx_load;
  assign step_page = wr_fire;
  assign wr_en     = wr_en_q;
  assign wr_addr   = wr_addr_q;
  assign wr_data   = wr_data_q;

  assert_pull_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_s);

  assert_idle_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_pull);

  assert_wr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  assert_wp_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !$past(wr_protect));

  assert_busy_refuse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_ack && phase == PH_SEL && !shreg[0] && prog_busy) |=> !sda_pull);

  assert_start_keeps_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> $stable(cur_addr));

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave #(
  parameter int         ADDR_W      = 10,
  parameter int         PAGE_W      = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  input  logic              sel_pin,
  input  logic              wr_protect,
  input  logic              prog_busy,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [7:0]        mem_wr_data
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic              ld, step_seq, step_page;
  logic [ADDR_W-1:0] ld_val, cur_addr;

  eeb_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_raw  (scl_in),
    .sda_raw  (sda_in),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  eeb_protocol #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) i_proto (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_ev   (start_ev),
    .stop_ev    (stop_ev),
    .sel_pin    (sel_pin),
    .wr_protect (wr_protect),
    .prog_busy  (prog_busy),
    .cur_addr   (cur_addr),
    .rd_data    (mem_rd_data),
    .sda_pull   (sda_pull),
    .ld         (ld),
    .ld_val     (ld_val),
    .step_seq   (step_seq),
    .step_page  (step_page),
    .wr_en      (mem_wr_en),
    .wr_addr    (mem_wr_addr),
    .wr_data    (mem_wr_data)
  );

  eeb_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_actr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld        (ld),
    .ld_val    (ld_val),
    .step_seq  (step_seq),
    .step_page (step_page),
    .cur       (cur_addr)
  );

  assign mem_rd_addr = cur_addr;

endmodule

// File: tb/test_serial_mem_slave.sv
module test_serial_mem_slave;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 8;
  localparam int AW         = 10;
  localparam int DEPTH      = 1 << AW;
  localparam logic SEL_PIN  = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wr_protect = 1'b0;
  logic prog_busy = 1'b0;
  logic sda_pull, mem_wr_en, sda_line;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [7:0] mem_rd_data, mem_wr_data;
  logic [7:0] mem [DEPTH];
  logic [7:0] exp_mem [DEPTH];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line    = sda_m & ~sda_pull;
  assign mem_rd_data = mem[mem_rd_addr];

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= pat(i);
    end else if (mem_wr_en) begin
      mem[mem_wr_addr] <= mem_wr_data;
    end
  end

  serial_mem_slave i_serial_mem_slave (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_in      (scl_m),
    .sda_in      (sda_line),
    .sda_pull    (sda_pull),
    .sel_pin     (SEL_PIN),
    .wr_protect  (wr_protect),
    .prog_busy   (prog_busy),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_data (mem_rd_data),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr),
    .mem_wr_data (mem_wr_data)
  );

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b, output logic r);
    sda_m = b; idle(H);
    scl_m = 1'b1; idle(H/2);
    r = sda_line; idle(H/2);
    scl_m = 1'b0; idle(H);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; idle(H);
    scl_m = 1'b1; idle(H);
    sda_m = 1'b0; idle(H);
    scl_m = 1'b0; idle(H);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; idle(H);
    scl_m = 1'b1; idle(H);
    sda_m = 1'b1; idle(H);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], r);
    clk_bit(1'b1, ack);
  endtask

  task automatic get_byte(input logic m_ack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      v[i] = r;
    end
    clk_bit(m_ack, r);
  endtask

  function automatic logic [7:0] sel_word(int a, logic rd);
    return {4'b1010, SEL_PIN, 2'(a >> 8), rd};
  endfunction

  // dummy write that loads address a, leaves the bus mid-transaction
  task automatic set_addr(int a);
    logic ack;
    bus_start;
    put_byte(sel_word(a, 1'b0), ack); chk("R10 dummy write select ack", ack, 0);
    put_byte(8'(a), ack);             chk("R10 dummy write address ack", ack, 0);
  endtask

  task automatic read_at(int a, output logic [7:0] v);
    logic ack;
    set_addr(a);
    bus_start;
    put_byte(sel_word(0, 1'b1), ack); chk("R10 random read select ack", ack, 0);
    get_byte(1'b1, v);
    bus_stop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack, r;
    logic [7:0] v, d, b;
    int wa [4];
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = pat(i);
    wa[0] = 'h000; wa[1] = 'h155; wa[2] = 'h2AA; wa[3] = 'h3FF;
    idle(4); rst_n = 1'b1; idle(4);

    chk("R13 sda_pull after reset", sda_pull, 0);

    // R13: current address read after reset, read select bits 2:1 ignored (R10)
    bus_start;
    put_byte(sel_word('h300, 1'b1), ack); chk("R1 read select ack", ack, 0);
    get_byte(1'b1, v); bus_stop;
    chk("R13 R10 R3 R4 reset address read", v, pat(0));

    // R1 R2: sweep of fixed code and pin bit
    for (int n = 0; n < 16; n++) begin
      for (int p = 0; p < 2; p++) begin
        b = {4'(n), 1'(p), 3'b000};
        bus_start;
        put_byte(b, ack);
        chk("R1 R2 select decode", ack, (n == 10 && p == int'(SEL_PIN)) ? 0 : 1);
        if (!(n == 10 && p == int'(SEL_PIN))) begin
          put_byte(8'h00, ack); chk("R2 ignored after mismatch", ack, 1);
        end
        bus_stop;
      end
    end

    // R5: byte writes across the address range
    for (int k = 0; k < 4; k++) begin
      d = 8'(wa[k] ^ 'h5A);
      bus_start;
      put_byte(sel_word(wa[k], 1'b0), ack); chk("R5 write select ack", ack, 0);
      put_byte(8'(wa[k]), ack);             chk("R5 address ack", ack, 0);
      put_byte(d, ack);                     chk("R5 data ack", ack, 0);
      bus_stop;
      exp_mem[wa[k]] = d;
    end
    // write to 0x3FF leaves the counter at the page start 0x3F0
    bus_start;
    put_byte(sel_word(0, 1'b1), ack); get_byte(1'b1, v); bus_stop;
    chk("R6 R10 current address after page-end write", v, exp_mem['h3F0]);
    for (int k = 0; k < 4; k++) begin
      read_at(wa[k], v);
      chk("R5 R4 random read of written byte", v, exp_mem[wa[k]]);
    end

    // R6: 18-byte burst from 0x1FE wraps inside page 0x1F0
    bus_start;
    put_byte(sel_word('h1FE, 1'b0), ack); put_byte(8'hFE, ack);
    for (int k = 0; k < 18; k++) begin
      put_byte(8'('hC0 + k), ack); chk("R6 burst data ack", ack, 0);
      exp_mem['h1F0 + (('hE + k) % 16)] = 8'('hC0 + k);
    end
    bus_stop;
    set_addr('h1EF);
    bus_start;
    put_byte(sel_word(0, 1'b1), ack); chk("R8 read select ack", ack, 0);
    for (int k = 0; k < 18; k++) begin
      get_byte((k < 17) ? 1'b0 : 1'b1, v);
      chk("R6 R8 sequential read over page", v, exp_mem['h1EF + k]);
    end
    bus_stop;

    // R7: write protect
    wr_protect = 1'b1;
    bus_start;
    put_byte(sel_word('h050, 1'b0), ack); chk("R7 select ack with protect", ack, 0);
    put_byte(8'h50, ack);                 chk("R7 address ack with protect", ack, 0);
    put_byte(8'hEE, ack);                 chk("R7 data nack with protect", ack, 1);
    put_byte(8'hEF, ack);                 chk("R7 second data nack with protect", ack, 1);
    bus_stop;
    wr_protect = 1'b0;
    read_at('h050, v);
    chk("R7 protected byte unchanged", v, exp_mem['h050]);

    // R8: wrap 1023 -> 0, then R9 release after master nack
    set_addr('h3FD);
    bus_start;
    put_byte(sel_word(0, 1'b1), ack); chk("R8 read select ack", ack, 0);
    for (int k = 0; k < 5; k++) begin
      get_byte((k < 4) ? 1'b0 : 1'b1, v);
      chk("R8 sequential wrap", v, exp_mem[('h3FD + k) % DEPTH]);
    end
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, r); chk("R9 line released after nack", r, 1);
    end
    bus_stop;
    bus_start;
    put_byte(sel_word(0, 1'b1), ack); get_byte(1'b1, v); bus_stop;
    chk("R10 current address after wrap", v, exp_mem[2]);

    // R11: repeated start in the middle of a data byte
    bus_start;
    put_byte(sel_word('h123, 1'b0), ack); put_byte(8'h23, ack);
    clk_bit(1'b1, r); clk_bit(1'b0, r); clk_bit(1'b1, r);
    bus_start;
    put_byte(sel_word(0, 1'b1), ack); chk("R11 select ack after repeated start", ack, 0);
    get_byte(1'b1, v); bus_stop;
    chk("R11 address kept and byte unchanged", v, exp_mem['h123]);

    // R12: program cycle busy
    prog_busy = 1'b1;
    bus_start;
    put_byte(sel_word(0, 1'b0), ack); chk("R12 write select refused while busy", ack, 1);
    bus_stop;
    bus_start;
    put_byte(sel_word(0, 1'b1), ack); chk("R12 read select served while busy", ack, 0);
    get_byte(1'b1, v); bus_stop;
    chk("R12 read data while busy", v, exp_mem['h124]);
    prog_busy = 1'b0;
    bus_start;
    put_byte(sel_word(0, 1'b0), ack); chk("R12 write select after busy", ack, 0);
    bus_stop;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule